// File: doc/BRIEF.md
# Command-Driven Watchdog Timer With Ownership Tags

This block is a watchdog countdown that a host controls with two command strobes instead of a bare kick line. A configure command supplies a 16-bit timeout and a three-bit ownership tag. The timeout is counted in units of an external 100 ms tick enable. The tag says which software phase owns the watchdog: early boot fault detection, power-on self test, operating system load, management software or operating system, or vendor software.

The configure command stops the timer. A separate restart command loads the configured timeout and counts it down once for each tick. If no restart arrives before the count runs out, the block gives a one-cycle expiry pulse. It also sets a sticky expired flag and reports the tag that owned the timer at that moment. A boot loader can arm the timer with the operating system load tag just before handing over. If the loaded system never restarts or reconfigures it, the expiry carries that tag. Commands that make no sense raise a one-cycle error pulse and change nothing.

Top module: `cmdWatchdog`

## Requirements
- R1: After reset the outputs read as follows: running 0, expired flag 0, expiry pulse 0, error pulse 0 and expired tag 0.
- R2: A configure command with a tag of 1 to 5 stores the timeout and tag and clears running on the next cycle. The tag encoding is 1 boot fault detection, 2 self test, 3 OS load, 4 management/OS and 5 vendor.
- R3: A configure command with tag 0, 6 or 7 gives a one-cycle error pulse on the next cycle. It leaves the stored timeout and tag unchanged.
- R4: A restart command that arrives before any valid configure command gives a one-cycle error pulse and leaves the timer stopped.
- R5: A restart command after a valid configure command loads the stored timeout and sets running on the next cycle. A restart while the timer is running reloads the full timeout.
- R6: While running, the count drops by one on each cycle with the tick enable high, and holds on every other cycle. With timeout N, the expiry pulse comes in the cycle after the edge that samples the Nth tick, and it lasts one cycle.
- R7: On expiry the sticky expired flag sets, the expired tag takes the stored tag, and running clears.
- R8: A restart in the same cycle as the tick that would end the count wins. The timer reloads and does not expire.
- R9: The sticky expired flag clears on the next valid configure command. A restart or a rejected configure command leaves it set.
- R10: A timeout field of 0 means 65536 ticks.
- R11: A configure command blocks any restart in the same cycle. Only the configure takes effect, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle 100 ms tick enable |
| cfgCmd | input | 1 | Configure command strobe |
| cfgTimeout | input | 16 | Timeout in ticks, 0 meaning 65536 |
| cfgTag | input | 3 | Ownership tag, valid 1 to 5 |
| restartCmd | input | 1 | Restart command strobe |
| expirePulse | output | 1 | One-cycle pulse on expiry |
| expiredFlag | output | 1 | Sticky expired flag |
| expiredTag | output | 3 | Tag that owned the timer at the last expiry |
| running | output | 1 | Countdown active |
| errPulse | output | 1 | One-cycle pulse on a rejected command |

## Verification
Every result is a register one edge behind the command or tick that causes it. This covers running, the error pulse, the cleared expired flag and the expiry pulse. An expiry with timeout N therefore appears right after the edge that samples the Nth tick. The bench drives inputs just after a rising edge and reads the outputs just after the following edge, so each check lands in the cycle where its result is due. Each countdown check reads the outputs after N-1 ticks to confirm no early expiry, and again after the Nth tick to confirm the expiry. Each pulse check reads the following cycle as well, to confirm the pulse has dropped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int TAG_W = 3;

  typedef enum logic [TAG_W-1:0] {
    TAG_NONE    = 3'd0,
    TAG_BOOTFLT = 3'd1,
    TAG_SELFTST = 3'd2,
    TAG_OSLOAD  = 3'd3,
    TAG_MGMTOS  = 3'd4,
    TAG_VENDOR  = 3'd5
  } ownerTag_e;

  localparam int TAG_FIRST = 1;
  localparam int TAG_LAST  = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic startCount;
  } wdtStrobe_t;
endpackage

// File: rtl/wdtControl.sv
module wdtControl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCmd,
  input  logic [TAG_W-1:0] cfgTag,
  input  logic             restartCmd,
  output wdtStrobe_t       strobe,
  output logic             errPulse
);
  logic configured;
  logic tagOk;
  logic rejectCfg;
  logic rejectRestart;
  logic [TAG_LAST:TAG_FIRST] tagHit;

  // One comparator per legal tag value
  for (genvar g = TAG_FIRST; g <= TAG_LAST; g++) begin : gTagCmp
    assign tagHit[g] = (cfgTag == TAG_W'(g));
  end
  assign tagOk = |tagHit;

  always_comb begin
    strobe            = '0;
    strobe.loadCfg    = cfgCmd && tagOk;
    strobe.startCount = restartCmd && !cfgCmd && configured;
    rejectCfg         = cfgCmd && !tagOk;
    rejectRestart     = restartCmd && !cfgCmd && !configured;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      configured <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      errPulse <= rejectCfg || rejectRestart;
      if (strobe.loadCfg) configured <= 1'b1;
    end
  end

  // R4
  early_restart_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restartCmd && !cfgCmd && !configured) |=> errPulse);
  // R11
  cfg_blocks_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgCmd |-> !strobe.startCount);
endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  wdtStrobe_t           strobe,
  input  logic [TIMEOUT_W-1:0] timeoutIn,
  input  logic [TAG_W-1:0]     tagIn,
  output logic                 expirePulse,
  output logic                 expiredFlag,
  output logic [TAG_W-1:0]     expiredTag,
  output logic                 running
);
  localparam int CNT_W = TIMEOUT_W + 1;
  localparam logic [CNT_W-1:0] FULL_RANGE = CNT_W'(1) << TIMEOUT_W;

  logic [TIMEOUT_W-1:0] storedTimeout;
  logic [TAG_W-1:0]     storedTag;
  logic [CNT_W-1:0]     count;
  logic [CNT_W-1:0]     loadVal;
  logic                 lastTick;

  assign loadVal  = (storedTimeout == '0) ? FULL_RANGE : CNT_W'(storedTimeout);
  assign lastTick = running && tickEn && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedTimeout <= '0;
      storedTag     <= '0;
      count         <= '0;
      running       <= 1'b0;
      expirePulse   <= 1'b0;
      expiredFlag   <= 1'b0;
      expiredTag    <= '0;
    end else begin
      expirePulse <= 1'b0;
      if (strobe.loadCfg) begin
        storedTimeout <= timeoutIn;
        storedTag     <= tagIn;
        running       <= 1'b0;
        expiredFlag   <= 1'b0;
      end else if (strobe.startCount) begin
        count   <= loadVal;
        running <= 1'b1;
      end else if (lastTick) begin
        count       <= '0;
        running     <= 1'b0;
        expirePulse <= 1'b1;
        expiredFlag <= 1'b1;
        expiredTag  <= storedTag;
      end else if (running && tickEn) begin
        count <= count - CNT_W'(1);
      end
    end
  end

  // R6
  expire_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> !expirePulse);
  // R7
  expire_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> (expiredFlag && !running));
  // R2
  cfg_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |=> (!running && !expiredFlag));
  // R5
  start_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startCount |=> running);
  // R6
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tickEn && !strobe.startCount && !strobe.loadCfg) |=> $stable(count));
endmodule

// File: rtl/cmdWatchdog.sv
module cmdWatchdog
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 cfgCmd,
  input  logic [TIMEOUT_W-1:0] cfgTimeout,
  input  logic [TAG_W-1:0]     cfgTag,
  input  logic                 restartCmd,
  output logic                 expirePulse,
  output logic                 expiredFlag,
  output logic [TAG_W-1:0]     expiredTag,
  output logic                 running,
  output logic                 errPulse
);
  wdtStrobe_t strobe;

  wdtControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCmd     (cfgCmd),
    .cfgTag     (cfgTag),
    .restartCmd (restartCmd),
    .strobe     (strobe),
    .errPulse   (errPulse)
  );

  wdtDatapath #(.TIMEOUT_W(TIMEOUT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .strobe      (strobe),
    .timeoutIn   (cfgTimeout),
    .tagIn       (cfgTag),
    .expirePulse (expirePulse),
    .expiredFlag (expiredFlag),
    .expiredTag  (expiredTag),
    .running     (running)
  );
endmodule

// File: tb/sim_cmdWatchdog.sv
`timescale 1ns/1ps
module sim_cmdWatchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        cfgCmd = 1'b0;
  logic [15:0] cfgTimeout = '0;
  logic [2:0]  cfgTag = '0;
  logic        restartCmd = 1'b0;
  logic        expirePulse, expiredFlag, running, errPulse;
  logic [2:0]  expiredTag;
  int          nRun = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  cmdWatchdog u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgCmd(cfgCmd),
    .cfgTimeout(cfgTimeout), .cfgTag(cfgTag), .restartCmd(restartCmd),
    .expirePulse(expirePulse), .expiredFlag(expiredFlag),
    .expiredTag(expiredTag), .running(running), .errPulse(errPulse)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    cfgCmd = 0; restartCmd = 0; tickEn = 0;
  endtask

  task automatic doCfg(input int t, input int tag);
    cfgCmd = 1; cfgTimeout = 16'(t); cfgTag = 3'(tag);
    cyc(); idle();
  endtask

  task automatic doRestart();
    restartCmd = 1;
    cyc(); idle();
  endtask

  task automatic ticks(input int n);
    tickEn = 1;
    for (int i = 0; i < n; i++) cyc();
    tickEn = 0;
  endtask

  task automatic tResetState();
    chk(!running && !expiredFlag && !expirePulse && !errPulse && expiredTag == 0,
        "R1 reset state", {running, expiredFlag, expirePulse, errPulse}, 0);
  endtask

  task automatic tEarlyRestart();
    doRestart();
    chk(errPulse == 1, "R4 err pulse", errPulse, 1);
    chk(running == 0, "R4 stays stopped", running, 0);
    cyc();
    chk(errPulse == 0, "R4 err one cycle", errPulse, 0);
  endtask

  task automatic tBasicExpire();
    doCfg(3, 3);
    chk(running == 0 && errPulse == 0, "R2 configured stopped", running, 0);
    doRestart();
    chk(running == 1, "R5 running after restart", running, 1);
    ticks(2);
    chk(expirePulse == 0 && running == 1, "R6 no early expiry", expirePulse, 0);
    ticks(1);
    chk(expirePulse == 1, "R6 expiry after N ticks", expirePulse, 1);
    chk(expiredFlag == 1 && running == 0, "R7 flag set, stopped", {expiredFlag, running}, 2);
    chk(expiredTag == 3, "R7 OS load tag", expiredTag, 3);
    cyc();
    chk(expirePulse == 0 && expiredFlag == 1, "R6 pulse one cycle", expirePulse, 0);
  endtask

  task automatic tStickyClear();
    doRestart();
    chk(expiredFlag == 1, "R9 restart keeps flag", expiredFlag, 1);
    doCfg(5, 7);
    chk(errPulse == 1 && expiredFlag == 1, "R9 rejected cfg keeps flag", expiredFlag, 1);
    chk(running == 1, "R3 rejected cfg leaves timer", running, 1);
    doCfg(4, 2);
    chk(expiredFlag == 0 && running == 0, "R9 valid cfg clears flag", expiredFlag, 0);
  endtask

  task automatic tRejectKeepsCfg();
    doCfg(2, 0);
    chk(errPulse == 1, "R3 tag 0 rejected", errPulse, 1);
    doCfg(2, 6);
    chk(errPulse == 1, "R3 tag 6 rejected", errPulse, 1);
    doRestart();
    ticks(3);
    chk(expirePulse == 0, "R3 old timeout kept", expirePulse, 0);
    ticks(1);
    chk(expirePulse == 1 && expiredTag == 2, "R3 old tag kept", expiredTag, 2);
  endtask

  task automatic tPaceAndReload();
    doCfg(3, 5);
    doRestart();
    tickEn = 1; cyc(); tickEn = 0;
    cyc(); cyc(); cyc();
    chk(running == 1 && expirePulse == 0, "R6 holds without tick", running, 1);
    tickEn = 1; cyc();
    tickEn = 1; restartCmd = 1; cyc(); idle();
    chk(expirePulse == 0 && running == 1, "R8 restart beats last tick", expirePulse, 0);
    ticks(2);
    chk(expirePulse == 0, "R5 reload full timeout", expirePulse, 0);
    ticks(1);
    chk(expirePulse == 1 && expiredTag == 5, "R5 expiry after reload", expiredTag, 5);
  endtask

  task automatic tCfgBeatsRestart();
    cfgCmd = 1; cfgTimeout = 16'd4; cfgTag = 3'd1; restartCmd = 1;
    cyc(); idle();
    chk(running == 0 && errPulse == 0, "R11 cfg wins, no err", {running, errPulse}, 0);
  endtask

  task automatic tFullRange();
    doCfg(0, 4);
    doRestart();
    ticks(65535);
    chk(expirePulse == 0 && running == 1, "R10 none at 65535", expirePulse, 0);
    ticks(1);
    chk(expirePulse == 1 && expiredTag == 4, "R10 expiry at 65536", expirePulse, 1);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1;
    tResetState();
    tEarlyRestart();
    tBasicExpire();
    tStickyClear();
    tRejectKeepsCfg();
    tPaceAndReload();
    tCfgBeatsRestart();
    tFullRange();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule